// File: doc/BRIEF.md
# Prefix-Code Byte Decompressor

This block expands a compressed configuration stream back into plain bytes. Compressed input arrives as bytes over a valid/ready port. Each byte is consumed one bit per cycle, most significant bit first. The bits are parsed as a prefix-free code with four kinds of codeword:

- a lone zero bit for the byte 0x00;
- a short codeword for a byte with exactly one bit set;
- a short codeword that selects one of eight stored bytes;
- a long escape codeword that carries a literal byte.

Decoded bytes leave through a second valid/ready port.

Before a frame is decoded, software fills the eight-entry byte table through a sequential write port. A frame-length input gives the number of decoded bytes in the frame. That count includes any leading zero bytes that the compressor added to reach a 64-bit boundary. Once the last byte of a frame has been produced, the rest of the current input byte is padding. The decoder discards it, and the next frame starts at the next input byte.

Top module: `pfx_byte_decomp`

## Requirements
- R1: After reset, `out_valid` and `out_last` are low and `in_ready` is high.
- R2: A single `0` bit decodes to the byte 0x00.
- R3: The bits `100` followed by a 3-bit position p (MSB first) decode to a byte with only bit p set, where bit 0 is the LSB. For example, `100101` gives 0x20.
- R4: The bits `101` followed by a 3-bit index i decode to the table entry i. For example, `101011` gives entry 3.
- R5: The bits `11` followed by eight bits decode to those eight bits as a byte, first bit as the MSB. This holds for any value, including 0x00.
- R6: Table writes fill entries in descending order. The first `dict_we` pulse after reset writes entry 7, each following pulse writes the next lower entry, and after entry 0 the next write goes to entry 7 again.
- R7: `frame_len` is taken when the first byte of a frame is decoded. `out_last` is high together with the frame_len-th decoded byte and low with all others.
- R8: The bits left in the current input byte after a frame's last byte are discarded, whatever their value. `in_ready` is high in the cycle after that byte is decoded.
- R9: While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold their values and no input bit is consumed.
- R10: Codewords may straddle input bytes. Gaps in `in_valid` and back-pressure do not change the decoded sequence. A byte that is accepted makes `in_ready` low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dict_we | input | 1 | Writes `dict_wdata` into the next table entry |
| dict_wdata | input | 8 | Table byte to store |
| in_valid | input | 1 | Compressed input byte valid |
| in_data | input | 8 | Compressed input byte, consumed MSB first |
| in_ready | output | 1 | Decoder can accept an input byte |
| frame_len | input | LEN_W | Decoded bytes in the current frame (must be nonzero) |
| out_valid | output | 1 | Decoded byte valid |
| out_data | output | 8 | Decoded byte |
| out_last | output | 1 | Marks the last decoded byte of the frame |
| out_ready | input | 1 | Consumer accepts the decoded byte |

## Verification
The hardest case to reach is a frame that ends in the middle of an input byte whose remaining bits are ones, at the same moment as the output is back-pressured. Non-zero padding after a frame end would corrupt the next frame if it were not discarded. To reach this case, the bench encodes frames of odd lengths, fills every trailing pad with ones, and pushes them back-to-back while `out_ready` and `in_valid` follow patterns that are not aligned with the codeword boundaries. Codewords then straddle input bytes, and frame ends meet stalled outputs.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
  localparam int DICT_DEPTH = 8;
  localparam int IDX_W      = $clog2(DICT_DEPTH);
  localparam int SYM_W      = 8;

  typedef enum logic [1:0] {PH_HEAD, PH_PFX2, PH_PFX3, PH_ARG} phase_t;
  typedef enum logic [1:0] {AK_ONEHOT, AK_DICT, AK_LIT} arg_kind_t;

  // Byte with a single bit set at the given position (0 = LSB).
  function automatic logic [SYM_W-1:0] onehot_sym(input logic [IDX_W-1:0] pos);
    logic [SYM_W-1:0] r;
    r = '0;
    r[pos] = 1'b1;
    return r;
  endfunction

  // Number of argument bits after the prefix of a codeword.
  function automatic logic [3:0] arg_len(input arg_kind_t k);
    return (k == AK_LIT) ? 4'(SYM_W) : 4'(IDX_W);
  endfunction
endpackage

// File: rtl/pfx_bit_feed.sv
module pfx_bit_feed
  import pfx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [SYM_W-1:0] in_data,
  output logic             in_ready,
  input  logic             take,
  input  logic             drop,
  output logic             bit_avail,
  output logic             bit_out
);
  localparam int CNT_W = $clog2(SYM_W + 1);

  logic [SYM_W-1:0] shreg;
  logic [CNT_W-1:0] left;

  assign in_ready  = (left == '0);
  assign bit_avail = (left != '0);
  assign bit_out   = shreg[SYM_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg <= '0;
      left  <= '0;
    end else if (drop) begin
      left <= '0;
    end else if (in_valid && in_ready) begin
      shreg <= in_data;
      left  <= CNT_W'(SYM_W);
    end else if (take) begin
      shreg <= {shreg[SYM_W-2:0], 1'b0};
      left  <= left - 1'b1;
    end
  end
endmodule

// File: rtl/pfx_dict.sv
module pfx_dict
  import pfx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [SYM_W-1:0] wdata,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [SYM_W-1:0] rd_data
);
  logic [SYM_W-1:0] mem [DICT_DEPTH];
  logic [IDX_W-1:0] wptr;

  assign rd_data = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= IDX_W'(DICT_DEPTH - 1);
      for (int i = 0; i < DICT_DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[wptr] <= wdata;
      wptr      <= (wptr == '0) ? IDX_W'(DICT_DEPTH - 1) : wptr - 1'b1;
    end
  end
endmodule

// File: rtl/pfx_code_fsm.sv
module pfx_code_fsm
  import pfx_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_avail,
  input  logic             bit_in,
  input  logic [LEN_W-1:0] frame_len,
  output logic [IDX_W-1:0] dict_idx,
  input  logic [SYM_W-1:0] dict_byte,
  output logic             take,
  output logic             code_done,
  output logic             drop,
  output logic             out_valid,
  output logic [SYM_W-1:0] out_data,
  output logic             out_last,
  input  logic             out_ready
);
  phase_t           phase;
  arg_kind_t        kind;
  logic [3:0]       need;
  logic [SYM_W-1:0] arg;
  logic [LEN_W-1:0] rem;

  logic [SYM_W-1:0] nxt_arg;
  logic [SYM_W-1:0] value;
  logic [LEN_W-1:0] cur_len;
  logic             is_last;
  logic             busy;

  assign busy     = out_valid && !out_ready;
  assign take     = bit_avail && !busy;
  assign nxt_arg  = {arg[SYM_W-2:0], bit_in};
  assign dict_idx = nxt_arg[IDX_W-1:0];
  assign cur_len  = (rem == '0) ? frame_len : rem;
  assign is_last  = (cur_len == LEN_W'(1));
  assign drop     = code_done && is_last;

  always_comb begin
    code_done = 1'b0;
    value     = '0;
    case (phase)
      PH_HEAD: code_done = take && !bit_in;
      PH_ARG: begin
        code_done = take && (need == 4'd1);
        case (kind)
          AK_LIT:    value = nxt_arg;
          AK_DICT:   value = dict_byte;
          default:   value = onehot_sym(nxt_arg[IDX_W-1:0]);
        endcase
      end
      default: code_done = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_HEAD;
      kind      <= AK_LIT;
      need      <= '0;
      arg       <= '0;
      rem       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
    end else begin
      if (take) begin
        case (phase)
          PH_HEAD: if (bit_in) phase <= PH_PFX2;
          PH_PFX2: begin
            if (bit_in) begin
              kind  <= AK_LIT;
              need  <= arg_len(AK_LIT);
              arg   <= '0;
              phase <= PH_ARG;
            end else begin
              phase <= PH_PFX3;
            end
          end
          PH_PFX3: begin
            kind  <= bit_in ? AK_DICT : AK_ONEHOT;
            need  <= arg_len(AK_DICT);
            arg   <= '0;
            phase <= PH_ARG;
          end
          default: begin
            arg  <= nxt_arg;
            need <= need - 1'b1;
            if (need == 4'd1) phase <= PH_HEAD;
          end
        endcase
      end
      if (code_done) begin
        out_valid <= 1'b1;
        out_data  <= value;
        out_last  <= is_last;
        rem       <= cur_len - 1'b1;
      end else if (out_ready) begin
        out_valid <= 1'b0;
        out_last  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pfx_byte_decomp.sv
module pfx_byte_decomp
  import pfx_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dict_we,
  input  logic [7:0]       dict_wdata,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             in_ready,
  input  logic [LEN_W-1:0] frame_len,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             out_last,
  input  logic             out_ready
);
  logic             bit_avail;
  logic             bit_val;
  logic             bit_take;
  logic             code_done;
  logic             pad_drop;
  logic [IDX_W-1:0] dict_idx;
  logic [SYM_W-1:0] dict_byte;

  pfx_bit_feed u_feed (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .take(bit_take), .drop(pad_drop),
    .bit_avail(bit_avail), .bit_out(bit_val)
  );

  pfx_dict u_dict (
    .clk(clk), .rst_n(rst_n),
    .we(dict_we), .wdata(dict_wdata),
    .rd_idx(dict_idx), .rd_data(dict_byte)
  );

  pfx_code_fsm #(.LEN_W(LEN_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .bit_avail(bit_avail), .bit_in(bit_val),
    .frame_len(frame_len),
    .dict_idx(dict_idx), .dict_byte(dict_byte),
    .take(bit_take), .code_done(code_done), .drop(pad_drop),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
    .out_ready(out_ready)
  );
endmodule

// File: rtl/pfx_byte_decomp_chk.sv
module pfx_byte_decomp_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_last,
  input logic       bit_take,
  input logic       code_done,
  input logic       pad_drop
);
  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  // R9
  no_take_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !bit_take && !code_done);

  // R7
  last_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  // R8
  pad_drop_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pad_drop |=> in_ready);

  // R10
  load_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready);
endmodule

bind pfx_byte_decomp pfx_byte_decomp_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_last(out_last),
  .bit_take(bit_take), .code_done(code_done), .pad_drop(pad_drop)
);

// File: tb/pfx_byte_decomp_tb.sv
module pfx_byte_decomp_tb;
  localparam int LEN_W = 16;
  localparam int WD    = 150000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             dict_we = 1'b0;
  logic [7:0]       dict_wdata = '0;
  logic             in_valid = 1'b0;
  logic [7:0]       in_data = '0;
  logic             in_ready;
  logic [LEN_W-1:0] frame_len = LEN_W'(1);
  logic             out_valid;
  logic [7:0]       out_data;
  logic             out_last;
  logic             out_ready = 1'b0;

  always #4 clk = ~clk;

  pfx_byte_decomp #(.LEN_W(LEN_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .dict_we(dict_we), .dict_wdata(dict_wdata),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .frame_len(frame_len), .out_valid(out_valid), .out_data(out_data),
    .out_last(out_last), .out_ready(out_ready)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  logic [7:0] mdict [8];
  int         mptr = 7;
  logic [7:0] in_q[$];
  logic [7:0] exp_q[$];
  bit         last_q[$];
  int         flen_q[$];
  string      cur_tag = "R1";
  int         rdy_mode = 0;
  int         gap_mode = 0;
  bit         prev_stall = 0;
  logic [7:0] prev_data = '0;
  bit         prev_last = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // One bench cycle: everything happens at the falling edge.
  task automatic tick();
    @(negedge clk);
    cyc++;
    if (cyc > WD) begin
      chk(0, "R10 watchdog pending", exp_q.size(), 0);
      finish_run();
    end
    if (prev_stall) begin
      chk(out_valid && out_data == prev_data && out_last == prev_last,
          "R9 hold", {out_valid, out_last, out_data}, {1'b1, prev_last, prev_data});
    end
    case (rdy_mode)
      0: out_ready = 1'b1;
      1: out_ready = (cyc % 3) != 0;
      default: out_ready = ($urandom % 3) != 0;
    endcase
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        chk(0, {cur_tag, " extra byte"}, out_data, 0);
      end else begin
        chk(out_data == exp_q[0], cur_tag, out_data, exp_q[0]);
        chk(out_last == last_q[0], "R7 last flag", out_last, last_q[0]);
        if (last_q[0]) begin
          void'(flen_q.pop_front());
          if (flen_q.size() > 0) frame_len = LEN_W'(flen_q[0]);
        end
        void'(exp_q.pop_front());
        void'(last_q.pop_front());
      end
    end
    prev_stall = out_valid && !out_ready;
    prev_data  = out_data;
    prev_last  = out_last;
    if (in_q.size() > 0 && (gap_mode == 0 || (gap_mode == 1 && cyc % 5 != 2) ||
                            (gap_mode == 2 && $urandom % 2 == 0))) begin
      in_valid = 1'b1;
      in_data  = in_q[0];
      if (in_ready) void'(in_q.pop_front());
    end else begin
      in_valid = 1'b0;
    end
  endtask

  // R6: model of the descending table fill
  task automatic dict_write(input logic [7:0] v);
    @(negedge clk);
    dict_we = 1'b1;
    dict_wdata = v;
    mdict[mptr] = v;
    mptr = (mptr == 0) ? 7 : mptr - 1;
    @(negedge clk);
    dict_we = 1'b0;
  endtask

  // Behavioural encoder: frame bytes -> packed compressed bytes
  task automatic add_frame(input logic [7:0] bytes[$], input bit lit_only, input bit pad_ones);
    bit bits[$];
    for (int k = 0; k < bytes.size(); k++) begin
      logic [7:0] b;
      int hit;
      b = bytes[k];
      hit = -1;
      for (int d = 7; d >= 0; d--) if (mdict[d] == b) hit = d;
      if (!lit_only && b == 8'h00) begin
        bits.push_back(0);
      end else if (!lit_only && $countones(b) == 1) begin
        int p;
        p = 0;
        for (int j = 0; j < 8; j++) if (b[j]) p = j;
        bits.push_back(1); bits.push_back(0); bits.push_back(0);
        for (int j = 2; j >= 0; j--) bits.push_back(p[j]);
      end else if (!lit_only && hit >= 0) begin
        bits.push_back(1); bits.push_back(0); bits.push_back(1);
        for (int j = 2; j >= 0; j--) bits.push_back(hit[j]);
      end else begin
        bits.push_back(1); bits.push_back(1);
        for (int j = 7; j >= 0; j--) bits.push_back(b[j]);
      end
      exp_q.push_back(b);
      last_q.push_back(k == bytes.size() - 1);
    end
    while (bits.size() % 8 != 0) bits.push_back(pad_ones);
    for (int k = 0; k < bits.size(); k += 8) begin
      logic [7:0] v;
      for (int j = 0; j < 8; j++) v[7-j] = bits[k+j];
      in_q.push_back(v);
    end
    flen_q.push_back(bytes.size());
  endtask

  // Hand-built stream bytes with a single expected byte
  task automatic add_raw(input logic [7:0] a, input logic [7:0] b, input int nb, input logic [7:0] exp);
    in_q.push_back(a);
    if (nb > 1) in_q.push_back(b);
    exp_q.push_back(exp);
    last_q.push_back(1);
    flen_q.push_back(1);
  endtask

  task automatic run(input string tag, input int rm, input int gm);
    cur_tag  = tag;
    rdy_mode = rm;
    gap_mode = gm;
    frame_len = LEN_W'(flen_q[0]);
    while (exp_q.size() > 0) tick();
    rdy_mode = 0;
    for (int k = 0; k < 4; k++) tick();
    chk(in_q.size() == 0, "R8 input drained", in_q.size(), 0);
    chk(in_ready == 1'b1, "R8 ready after frame", in_ready, 1);
  endtask

  function automatic logic [7:0] pick_byte();
    int r;
    r = $urandom % 4;
    case (r)
      0: return 8'h00;
      1: return 8'(1) << ($urandom % 8);
      2: return mdict[$urandom % 8];
      default: return 8'($urandom);
    endcase
  endfunction

  initial begin
    logic [7:0] fr[$];
    for (int i = 0; i < 8; i++) mdict[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(out_valid == 0 && out_last == 0, "R1 outputs idle", {out_valid, out_last}, 0);
    chk(in_ready == 1, "R1 in_ready", in_ready, 1);

    // R6: fill order 7 down to 0
    dict_write(8'h5A); dict_write(8'hC3); dict_write(8'h99); dict_write(8'h7E);
    dict_write(8'h81); dict_write(8'h3C); dict_write(8'hF0); dict_write(8'h0F);

    // R3: 100101 + pad 11 -> 0x20
    add_raw(8'h97, 8'h00, 1, 8'h20);
    run("R3", 0, 0);
    // R4: 101011 + pad 00 -> entry 3
    add_raw(8'hAC, 8'h00, 1, mdict[3]);
    run("R4", 0, 0);
    // R2 / R8: 0 then seven pad ones -> 0x00
    add_raw(8'h7F, 8'h00, 1, 8'h00);
    run("R2", 0, 0);
    // R5: 11 10100101 + pad -> 0xA5
    add_raw(8'hE9, 8'h40, 2, 8'hA5);
    run("R5", 0, 0);

    // R10: mixed frame, codes straddle bytes, leading zero bytes
    fr = {8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00,
          8'h01, 8'h80, mdict[0], mdict[7], 8'hA7, 8'h00, 8'h10, mdict[4],
          8'hFF, 8'h6B, 8'h02, mdict[2], 8'h00, 8'h33, 8'h40, mdict[5]};
    add_frame(fr, 0, 0);
    run("R10", 0, 0);

    // R5: literal-only encoding including zero and single-bit values
    fr = {8'h00, 8'h08, mdict[1], 8'hE4, 8'h00};
    add_frame(fr, 1, 1);
    run("R5", 0, 1);

    // R7 / R8 / R9: back-to-back frames, ones padding, stalls and gaps
    for (int f = 0; f < 4; f++) begin
      int n;
      n = (f == 0) ? 5 : (f == 1) ? 13 : (f == 2) ? 1 : 9;
      fr = {};
      for (int k = 0; k < n; k++) fr.push_back(pick_byte());
      add_frame(fr, 0, 1);
    end
    run("R9", 1, 1);

    // R6: three more writes land on entries 7, 6, 5; entry 4 untouched
    dict_write(8'h11); dict_write(8'h22); dict_write(8'h33);
    fr = {8'h11, mdict[4], 8'h33, 8'h22, mdict[0]};
    add_frame(fr, 0, 1);
    run("R6", 2, 2);

    // R10: long random frames under random back-pressure and gaps
    for (int f = 0; f < 3; f++) begin
      fr = {};
      for (int k = 0; k < 120 + f * 7; k++) fr.push_back(pick_byte());
      add_frame(fr, 0, f[0]);
    end
    run("R10", 2, 2);

    finish_run();
  end
endmodule